// File: doc/BRIEF.md
# Full-Duplex Codec Serial Transceiver

This block is the serial data path of a codec link of the kind used by a software modem. Two single-cycle strobes pace it: a launch strobe that marks the bit-clock edge on which outgoing data changes, and a sample strobe that marks the opposite edge, on which incoming data is captured. A start-of-frame strobe, given together with a launch strobe, opens one word slot. In that slot the block shifts one word out on its transmit line and, at the same time, shifts one word in from its receive line.

The outgoing word is taken from a transmit FIFO through a valid/ready pair. The incoming word is handed to a receive FIFO as a single-cycle valid pulse. The word length is programmable and is always sent most significant bit first. The bit clock, frame sync generation, the FIFOs themselves and interrupt logic all sit outside the block.

The receiver may run on its own. The transmitter runs only while the receiver is enabled too. After the last bit of a word, both directions stay idle until the next start of frame.

Top module: `codec_duplex_xcvr`

## Requirements
- R1: After reset `tx_line`, `tx_ready`, `rx_valid` and `rx_overrun` are all 0.
- R2: A slot opens only when `frame_start` and `bit_launch` are both high, `rx_en` is 1 and no receive word is in progress. `tx_ready` is high in exactly that cycle when `tx_en` and `tx_valid` are also 1, and the word on `tx_data` is then consumed.
- R3: The transmit word goes out MSB first, bit `len-1` down to bit 0. Each bit appears on `tx_line` one clock after its `bit_launch` strobe (the first bit after the opening strobe) and holds between launch strobes.
- R4: The receiver captures `rx_line` on the `len` `bit_sample` strobes that follow the opening. The first capture is the MSB. One clock after the last capture it raises `rx_valid` for one cycle, with the word right-aligned on `rx_data` and all bits above `len-1` at 0.
- R5: If `tx_valid` is 0 when a slot opens, `tx_line` stays 0 for the whole slot.
- R6: With `tx_en` set and `rx_en` clear, no slot opens: `tx_ready` stays 0, `tx_line` stays 0 and no `rx_valid` pulse occurs.
- R7: With `rx_en` set and `tx_en` clear, words are still received, while `tx_ready` and `tx_line` stay 0.
- R8: After the last bit of a word, `tx_line` returns to 0 on the next launch strobe. No further receive word is produced until a new start of frame. A start-of-frame strobe that comes while a receive word is in progress is ignored.
- R9: The effective word length is `word_len` clamped to the range 8 to 32. It is sampled when the slot opens.
- R10: If `rx_ready` is 0 during the `rx_valid` pulse, the word is dropped. `rx_overrun` becomes 1 on the next clock and stays 1 until reset.
- R11: A receive line held at 0 during a slot yields an all-zero word that is still delivered with a full `rx_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_launch | input | 1 | Strobe for the bit-clock edge that launches transmit data |
| bit_sample | input | 1 | Strobe for the bit-clock edge that samples receive data |
| frame_start | input | 1 | Start-of-frame strobe, valid together with `bit_launch` |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| word_len | input | 6 | Requested word length in bits (clamped to 8..32) |
| tx_data | input | 32 | Word offered by the transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_ready | output | 1 | Word on `tx_data` is consumed this cycle |
| tx_line | output | 1 | Serial transmit line |
| rx_line | input | 1 | Serial receive line |
| rx_data | output | 32 | Received word, right-aligned |
| rx_valid | output | 1 | Single-cycle pulse: `rx_data` holds a new word |
| rx_ready | input | 1 | Receive FIFO can accept a word |
| rx_overrun | output | 1 | Sticky flag: a received word was dropped |

## Verification
`tx_ready` is combinational and due in the same cycle as the opening strobe, so the bench reads it one nanosecond after driving that strobe. Each transmit bit is due one clock after its launch strobe. The bench drives strobes on falling edges and reads `tx_line` at the falling edge that follows the registering rising edge. The received word is due one clock after the last sample strobe, and `rx_overrun` one clock after a refused pulse. A falling-edge monitor pops the scoreboard queue only in cycles where `rx_valid` is high, and the driver counts the pulses per slot so that missing, extra and dropped words are all caught.

// File: rtl/codec_xcvr_pkg.sv
package codec_xcvr_pkg;

   function automatic int unsigned clamp_len(input int unsigned req,
                                             input int unsigned lo,
                                             input int unsigned hi);
      if (req < lo)      return lo;
      else if (req > hi) return hi;
      else               return req;
   endfunction

   typedef enum logic [0:0] {
      RX_IDLE  = 1'b0,
      RX_SHIFT = 1'b1
   } rx_phase_t;

endpackage

// File: rtl/codec_frame_ctrl.sv
module codec_frame_ctrl
   import codec_xcvr_pkg::*;
#(
   parameter int unsigned MIN_LEN = 8,
   parameter int unsigned MAX_LEN = 32,
   localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
   input  logic             bit_launch,
   input  logic             frame_start,
   input  logic             tx_en,
   input  logic             rx_en,
   input  logic             tx_valid,
   input  logic             rx_busy,
   input  logic [LEN_W-1:0] word_len,
   output logic             slot_open,
   output logic             tx_take,
   output logic [LEN_W-1:0] len_eff
);

   always_comb begin
      slot_open = frame_start && bit_launch && rx_en && !rx_busy;
      tx_take   = slot_open && tx_en && tx_valid;
      len_eff   = LEN_W'(clamp_len(int'(word_len), MIN_LEN, MAX_LEN));
   end

endmodule

// File: rtl/codec_tx_shifter.sv
module codec_tx_shifter #(
   parameter int unsigned MAX_LEN   = 32,
   parameter bit          MSB_FIRST = 1'b1,
   localparam int unsigned LEN_W    = $clog2(MAX_LEN + 1),
   localparam int unsigned IDX_W    = $clog2(MAX_LEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_launch,
   input  logic               slot_open,
   input  logic               load_valid,
   input  logic [MAX_LEN-1:0] load_word,
   input  logic [LEN_W-1:0]   len_eff,
   output logic               tx_line
);

   logic [MAX_LEN-1:0] word_q;
   logic [LEN_W-1:0]   len_q;
   logic [LEN_W-1:0]   cnt_q;
   logic               busy_q;
   logic               line_q;
   logic [IDX_W-1:0]   first_idx;
   logic [IDX_W-1:0]   next_idx;
   logic [MAX_LEN-1:0] slot_word;

   generate
      if (MSB_FIRST) begin : g_msb_first
         assign first_idx = IDX_W'(len_eff - 1'b1);
         assign next_idx  = IDX_W'(len_q - 1'b1 - cnt_q);
      end else begin : g_lsb_first
         assign first_idx = '0;
         assign next_idx  = IDX_W'(cnt_q);
      end
   endgenerate

   assign slot_word = load_valid ? load_word : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         len_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         line_q <= 1'b0;
      end else if (slot_open) begin
         word_q <= slot_word;
         len_q  <= len_eff;
         cnt_q  <= LEN_W'(1);
         busy_q <= 1'b1;
         line_q <= slot_word[first_idx];
      end else if (bit_launch && busy_q) begin
         if (cnt_q == len_q) begin
            busy_q <= 1'b0;
            line_q <= 1'b0;
         end else begin
            line_q <= word_q[next_idx];
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   assign tx_line = line_q;

endmodule

// File: rtl/codec_rx_shifter.sv
module codec_rx_shifter
   import codec_xcvr_pkg::*;
#(
   parameter int unsigned MAX_LEN   = 32,
   parameter bit          MSB_FIRST = 1'b1,
   localparam int unsigned LEN_W    = $clog2(MAX_LEN + 1),
   localparam int unsigned IDX_W    = $clog2(MAX_LEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_sample,
   input  logic               slot_open,
   input  logic [LEN_W-1:0]   len_eff,
   input  logic               rx_line,
   input  logic               rx_ready,
   output logic               rx_busy,
   output logic [MAX_LEN-1:0] rx_data,
   output logic               rx_valid,
   output logic               rx_overrun
);

   rx_phase_t          phase_q;
   logic [MAX_LEN-1:0] shift_q;
   logic [LEN_W-1:0]   len_q;
   logic [LEN_W-1:0]   cnt_q;
   logic               valid_q;
   logic               overrun_q;
   logic [IDX_W-1:0]   put_idx;

   generate
      if (MSB_FIRST) begin : g_msb_first
         assign put_idx = IDX_W'(len_q - 1'b1 - cnt_q);
      end else begin : g_lsb_first
         assign put_idx = IDX_W'(cnt_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= RX_IDLE;
         shift_q   <= '0;
         len_q     <= '0;
         cnt_q     <= '0;
         valid_q   <= 1'b0;
         overrun_q <= 1'b0;
      end else begin
         valid_q   <= 1'b0;
         overrun_q <= overrun_q | (valid_q & ~rx_ready);
         if (slot_open) begin
            phase_q <= RX_SHIFT;
            shift_q <= '0;
            len_q   <= len_eff;
            cnt_q   <= '0;
         end else if (phase_q == RX_SHIFT && bit_sample) begin
            shift_q[put_idx] <= rx_line;
            cnt_q            <= cnt_q + 1'b1;
            if (cnt_q == len_q - 1'b1) begin
               phase_q <= RX_IDLE;
               valid_q <= 1'b1;
            end
         end
      end
   end

   assign rx_busy    = (phase_q == RX_SHIFT);
   assign rx_data    = shift_q;
   assign rx_valid   = valid_q;
   assign rx_overrun = overrun_q;

endmodule

// File: rtl/codec_duplex_xcvr.sv
module codec_duplex_xcvr #(
   parameter int unsigned MIN_LEN   = 8,
   parameter int unsigned MAX_LEN   = 32,
   parameter bit          MSB_FIRST = 1'b1,
   localparam int unsigned LEN_W    = $clog2(MAX_LEN + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_launch,
   input  logic               bit_sample,
   input  logic               frame_start,
   input  logic               tx_en,
   input  logic               rx_en,
   input  logic [LEN_W-1:0]   word_len,
   input  logic [MAX_LEN-1:0] tx_data,
   input  logic               tx_valid,
   output logic               tx_ready,
   output logic               tx_line,
   input  logic               rx_line,
   output logic [MAX_LEN-1:0] rx_data,
   output logic               rx_valid,
   input  logic               rx_ready,
   output logic               rx_overrun
);

   generate
      if (MIN_LEN < 1) begin : g_bad_min
         $error("MIN_LEN must be at least 1");
      end
      if (MIN_LEN > MAX_LEN) begin : g_bad_range
         $error("MIN_LEN must not exceed MAX_LEN");
      end
      if (MAX_LEN < 2 || MAX_LEN > 64) begin : g_bad_max
         $error("MAX_LEN must lie in 2..64");
      end
   endgenerate

   logic             slot_open;
   logic             tx_take;
   logic             rx_busy;
   logic [LEN_W-1:0] len_eff;

   codec_frame_ctrl #(
      .MIN_LEN (MIN_LEN),
      .MAX_LEN (MAX_LEN)
   ) u_ctrl (
      .bit_launch  (bit_launch),
      .frame_start (frame_start),
      .tx_en       (tx_en),
      .rx_en       (rx_en),
      .tx_valid    (tx_valid),
      .rx_busy     (rx_busy),
      .word_len    (word_len),
      .slot_open   (slot_open),
      .tx_take     (tx_take),
      .len_eff     (len_eff)
   );

   codec_tx_shifter #(
      .MAX_LEN   (MAX_LEN),
      .MSB_FIRST (MSB_FIRST)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_launch (bit_launch),
      .slot_open  (slot_open),
      .load_valid (tx_take),
      .load_word  (tx_data),
      .len_eff    (len_eff),
      .tx_line    (tx_line)
   );

   codec_rx_shifter #(
      .MAX_LEN   (MAX_LEN),
      .MSB_FIRST (MSB_FIRST)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_sample (bit_sample),
      .slot_open  (slot_open),
      .len_eff    (len_eff),
      .rx_line    (rx_line),
      .rx_ready   (rx_ready),
      .rx_busy    (rx_busy),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .rx_overrun (rx_overrun)
   );

   assign tx_ready = tx_take;

endmodule

// File: rtl/codec_duplex_xcvr_chk.sv
module codec_duplex_xcvr_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_launch,
   input logic bit_sample,
   input logic frame_start,
   input logic tx_en,
   input logic rx_en,
   input logic tx_valid,
   input logic tx_ready,
   input logic tx_line,
   input logic rx_valid,
   input logic rx_ready,
   input logic rx_overrun
);

   assert_tx_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (rx_en && tx_en));

   assert_take_on_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (frame_start && bit_launch && tx_valid));

   assert_line_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_launch |=> $stable(tx_line));

   assert_valid_after_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(bit_sample));

   assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready) |=> rx_overrun);

   assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |=> rx_overrun);

endmodule

bind codec_duplex_xcvr codec_duplex_xcvr_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bit_launch  (bit_launch),
   .bit_sample  (bit_sample),
   .frame_start (frame_start),
   .tx_en       (tx_en),
   .rx_en       (rx_en),
   .tx_valid    (tx_valid),
   .tx_ready    (tx_ready),
   .tx_line     (tx_line),
   .rx_valid    (rx_valid),
   .rx_ready    (rx_ready),
   .rx_overrun  (rx_overrun)
);

// File: tb/codec_duplex_xcvr_test.sv
`timescale 1ns/1ps
module codec_duplex_xcvr_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_launch = 1'b0;
   logic        bit_sample = 1'b0;
   logic        frame_start = 1'b0;
   logic        tx_en = 1'b0;
   logic        rx_en = 1'b0;
   logic [5:0]  word_len = 6'd8;
   logic [31:0] tx_data = '0;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic        tx_line;
   logic        rx_line = 1'b0;
   logic [31:0] rx_data;
   logic        rx_valid;
   logic        rx_ready = 1'b1;
   logic        rx_overrun;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   logic [31:0] exp_q[$];

   always #4 clk = ~clk;

   codec_duplex_xcvr uut (
      .clk(clk), .rst_n(rst_n), .bit_launch(bit_launch), .bit_sample(bit_sample),
      .frame_start(frame_start), .tx_en(tx_en), .rx_en(rx_en), .word_len(word_len),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line),
      .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .rx_overrun(rx_overrun)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, got, exp);
      end
   endtask

   // scoreboard monitor: R4 words are popped as the design delivers them
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         pulses++;
         if (rx_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R4 unexpected word actual %h expected none", rx_data);
            end else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               if (rx_data !== e) begin
                  errors++;
                  $display("FAIL R4 received word actual %h expected %h", rx_data, e);
               end
            end
         end
      end
   end

   task automatic bit_cycle(input logic st, input logic rb, output logic txb, output logic rdy);
      @(negedge clk);
      bit_launch = 1'b1; frame_start = st; rx_line = rb;
      #1 rdy = tx_ready;
      @(negedge clk);
      bit_launch = 1'b0; frame_start = 1'b0;
      txb = tx_line;
      @(negedge clk);
      bit_sample = 1'b1;
      @(negedge clk);
      bit_sample = 1'b0;
   endtask

   task automatic run_frame(input string tag, input int raw_len, input int len,
                            input logic ten, input logic ren, input logic tv, input logic rdy,
                            input logic [31:0] txw, input logic [31:0] rxw, input int mid);
      logic [31:0] mask, got_tx, exp_tx;
      logic b, r;
      int start_pulses;
      mask   = (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
      exp_tx = (ten && ren && tv) ? (txw & mask) : 32'h0;
      got_tx = '0;
      @(negedge clk);
      word_len = 6'(raw_len); tx_en = ten; rx_en = ren; tx_valid = tv;
      tx_data = txw; rx_ready = rdy;
      start_pulses = pulses;
      if (ren && rdy) exp_q.push_back(rxw & mask);
      for (int i = 0; i < len; i++) begin
         bit_cycle((i == 0) || (i == mid), rxw[len-1-i], b, r);
         got_tx[len-1-i] = b;
         if (i == 0) begin
            check({tag, " tx_ready at open"}, {31'b0, r}, {31'b0, ten && ren && tv});
            tx_valid = 1'b0;
         end
      end
      bit_cycle(1'b0, 1'b0, b, r);
      check({tag, " R8 line idle after word"}, {31'b0, b}, 32'h0);
      repeat (2) @(negedge clk);
      check({tag, " tx word"}, got_tx, exp_tx);
      check({tag, " rx pulse count"}, 32'(pulses - start_pulses), {31'b0, ren});
      check({tag, " rx queue drained"}, 32'(exp_q.size()), 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 tx_line reset", {31'b0, tx_line}, 32'h0);
      check("R1 tx_ready reset", {31'b0, tx_ready}, 32'h0);
      check("R1 rx_valid reset", {31'b0, rx_valid}, 32'h0);
      check("R1 rx_overrun reset", {31'b0, rx_overrun}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R3 R4: full duplex, several lengths and patterns
      run_frame("R2 R3 R4 len16", 16, 16, 1, 1, 1, 1, 32'h0000_A5C3, 32'h0000_1234, -1);
      run_frame("R2 R3 R4 len8",   8,  8, 1, 1, 1, 1, 32'h0000_0081, 32'h0000_007E, -1);
      run_frame("R2 R3 R4 len32", 32, 32, 1, 1, 1, 1, 32'hDEAD_BEEF, 32'h8000_0001, -1);
      run_frame("R3 R4 len20", 20, 20, 1, 1, 1, 1, 32'hFFF5_5AA5, 32'hFFFC_3333, -1);
      // R5: empty transmit FIFO
      run_frame("R5 empty fifo", 12, 12, 1, 1, 0, 1, 32'h0000_0FFF, 32'h0000_0A5A, -1);
      // R6: transmit enabled without receive
      run_frame("R6 tx without rx", 16, 16, 1, 0, 1, 1, 32'h0000_FFFF, 32'h0000_BEEF, -1);
      // R7: receive only
      run_frame("R7 rx only", 10, 10, 0, 1, 1, 1, 32'h0000_03FF, 32'h0000_02D5, -1);
      // R8: start strobe mid-word ignored
      run_frame("R8 mid start", 16, 16, 1, 1, 1, 1, 32'h0000_C001, 32'h0000_5A0F, 5);
      // R9: clamping of the length
      run_frame("R9 clamp low", 3, 8, 1, 1, 1, 1, 32'h0000_00B7, 32'h0000_00C9, -1);
      run_frame("R9 clamp high", 40, 32, 1, 1, 1, 1, 32'h1357_9BDF, 32'hF0E1_D2C3, -1);
      // R11: quiet receive line gives zero word
      run_frame("R11 zero fill", 24, 24, 1, 1, 1, 1, 32'h00AB_CDEF, 32'h0, -1);
      check("R10 no overrun yet", {31'b0, rx_overrun}, 32'h0);
      // R10: refused word dropped, flag sticky
      run_frame("R10 refused", 8, 8, 1, 1, 1, 0, 32'h0000_0055, 32'h0000_00AA, -1);
      check("R10 overrun set", {31'b0, rx_overrun}, 32'h1);
      run_frame("R10 after overrun", 8, 8, 1, 1, 1, 1, 32'h0000_0033, 32'h0000_00CC, -1);
      check("R10 overrun sticky", {31'b0, rx_overrun}, 32'h1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule